// File: doc/BRIEF.md
# Clock Multiplier Configuration Register Bank

This block is the byte-wide register bank that configures a frequency multiplier. It holds three settings: a 14-bit multiplier value, a 5-bit divider value and a 14-bit integrator seed. The seed is a starting point for the lock loop and lets the loop reach the target frequency quickly. Bus writes to the value registers do not reach the multiplier at once. They land in a staging copy. A write to the control register then commits the staged copy to the active settings. A normal commit transfers the multiplier and divider, and the lock loop searches for its own seed. A fast commit also transfers the staged seed, so the loop can lock without a search.

Reads of the value registers return the active settings, not the staged ones. Software can therefore record the seed of a locked setting and load it again later. The control register also reports three status inputs: multiplier enabled, output stable and seed readback valid. It also carries a sticky flag that marks a rejected command. The oscillator and the lock loop are outside this block. It drives them through the active-value outputs and two one-cycle start pulses.

The register bus is a plain control port with no handshake. A write completes in the cycle `bus_wr` is sampled, and `bus_rdata` follows `bus_addr` combinationally. No streaming data passes through the block, so it has no valid/ready interface.

Top module: `clkmul_cfg_bank`

## Requirements
- R1: After reset the active multiplier is 14'h04C5, the active divider is 5'h0A and the active seed is 0. Register 1 reads C5h, register 2 reads 04h and register 3 reads 0Ah. Both start pulses are low.
- R2: The address map is 0 control, 1 multiplier bits 7..0, 2 multiplier bits 13..8 in data bits 5..0, 3 divider in data bits 4..0, 4 seed bits 7..0, and 5 seed bits 13..8 in data bits 5..0. Writes to registers 1 to 5 change only the staged copy. The active outputs and the readback of those registers stay unchanged until a commit.
- R3: A control write with bit 0 = 1 and bit 1 = 0 is a normal commit. On that clock edge it copies the staged multiplier and divider to the active outputs and leaves the active seed unchanged. `search_start_o` is high for exactly the following cycle.
- R4: A control write with bit 1 = 1 and bit 0 = 0 is a fast commit. On that clock edge it copies the staged multiplier, divider and seed to the active outputs. `fast_start_o` is high for exactly the following cycle.
- R5: A control write with bits 1 and 0 both set commits nothing and raises no pulse. It sets control bit 5, the command-error flag. That flag stays set until the next accepted commit clears it. The two pulses are never high together.
- R6: A read of the control register returns 0 in bits 1..0. Bit 2 mirrors `mult_en_i`, bit 3 mirrors `clk_stable_i`, bit 4 mirrors `seed_valid_i` and bits 7..6 are 0. Writes to bits 7..2 have no effect.
- R7: Reserved bits read as 0: bits 7..6 of registers 2 and 5, and bits 7..5 of register 3. Write data in those bit positions is discarded.
- R8: Addresses 6 and 7 read as 0, and writes to them change no staged or active value.
- R9: The staged copy is kept across a commit, so a later commit without new writes transfers the same values again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per sampled cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| mult_en_i | input | 1 | Multiplier enabled status |
| clk_stable_i | input | 1 | Output oscillating and stable status |
| seed_valid_i | input | 1 | Seed readback valid status |
| mult_o | output | 14 | Active multiplier value |
| div_o | output | 5 | Active divider value |
| seed_o | output | 14 | Active integrator seed |
| search_start_o | output | 1 | One-cycle pulse after a normal commit |
| fast_start_o | output | 1 | One-cycle pulse after a fast commit |

## Verification
Active outputs, start pulses and the error flag all change on the clock edge that samples the write. They are due one edge after the stimulus, and each pulse must be gone one edge later. The bench drives the bus on falling edges and checks these results at the next falling edge, then again one cycle later for pulse width. Read data is combinational from the active registers and the status inputs. It is checked one nanosecond after `bus_addr` changes, with no clock edge in between.

// File: rtl/clkmul_cfg_pkg.sv
package clkmul_cfg_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_MLO   = 3'd1,
    REG_MHI   = 3'd2,
    REG_DIV   = 3'd3,
    REG_SLO   = 3'd4,
    REG_SHI   = 3'd5
  } reg_addr_e;

  // control byte bit positions (command bits are fixed by software convention)
  localparam int CB_NORMAL = 0;
  localparam int CB_FAST   = 1;
  localparam int CB_EN     = 2;
  localparam int CB_STABLE = 3;
  localparam int CB_SVALID = 4;
  localparam int CB_ERR    = 5;
endpackage

// File: rtl/clkmul_stage.sv
// Staging copy of one field, written one byte lane at a time.
module clkmul_stage #(
  parameter int W       = 14,
  parameter logic [W-1:0] RST = '0,
  parameter int LO_ADDR = 1,
  parameter int HI_ADDR = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [2:0]   addr,
  input  logic [7:0]   wdata,
  output logic [W-1:0] q
);
  localparam int LO_W = (W > 8) ? 8 : W;
  localparam int HI_W = (W > 8) ? W - 8 : 1;

  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lo_q <= RST[LO_W-1:0];
    else if (wr && addr == 3'(LO_ADDR)) lo_q <= wdata[LO_W-1:0];
  end

  generate
    if (W > 8) begin : g_two_lanes
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= RST[W-1:LO_W];
        else if (wr && addr == 3'(HI_ADDR)) hi_q <= wdata[HI_W-1:0];
      end
      assign q = {hi_q, lo_q};
    end else begin : g_one_lane
      assign q = lo_q;
    end
  endgenerate
endmodule

// File: rtl/clkmul_active.sv
// Active copy of one field, loaded in one cycle on commit.
module clkmul_active #(
  parameter int W = 14,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RST;
    else if (load) q <= d;
  end
endmodule

// File: rtl/clkmul_cmd.sv
// Decodes control writes into commits, start pulses and the error flag.
module clkmul_cmd
  import clkmul_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic       commit_norm,
  output logic       commit_fast,
  output logic       search_q,
  output logic       fast_q,
  output logic       err_q
);
  logic ctrl_wr;
  assign ctrl_wr     = wr && addr == REG_CTRL;
  assign commit_norm = ctrl_wr &&  wdata[CB_NORMAL] && !wdata[CB_FAST];
  assign commit_fast = ctrl_wr && !wdata[CB_NORMAL] &&  wdata[CB_FAST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      search_q <= 1'b0;
      fast_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      search_q <= commit_norm;
      fast_q   <= commit_fast;
      if (ctrl_wr && wdata[CB_NORMAL] && wdata[CB_FAST]) err_q <= 1'b1;
      else if (commit_norm || commit_fast)               err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/clkmul_cfg_bank.sv
module clkmul_cfg_bank
  import clkmul_cfg_pkg::*;
#(
  parameter int MULT_W = 14,
  parameter int DIV_W  = 5,
  parameter int SEED_W = 14,
  parameter logic [MULT_W-1:0] MULT_RST = 14'h04C5,
  parameter logic [DIV_W-1:0]  DIV_RST  = 5'h0A,
  parameter logic [SEED_W-1:0] SEED_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              mult_en_i,
  input  logic              clk_stable_i,
  input  logic              seed_valid_i,
  output logic [MULT_W-1:0] mult_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [SEED_W-1:0] seed_o,
  output logic              search_start_o,
  output logic              fast_start_o
);
  logic [MULT_W-1:0] mult_stg;
  logic [DIV_W-1:0]  div_stg;
  logic [SEED_W-1:0] seed_stg;
  logic commit_norm, commit_fast, err_q;

  clkmul_stage #(.W(MULT_W), .RST(MULT_RST), .LO_ADDR(REG_MLO), .HI_ADDR(REG_MHI)) i_mult_stg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .q(mult_stg));
  clkmul_stage #(.W(DIV_W), .RST(DIV_RST), .LO_ADDR(REG_DIV), .HI_ADDR(REG_DIV)) i_div_stg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .q(div_stg));
  clkmul_stage #(.W(SEED_W), .RST(SEED_RST), .LO_ADDR(REG_SLO), .HI_ADDR(REG_SHI)) i_seed_stg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .q(seed_stg));

  clkmul_cmd i_cmd (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .commit_norm(commit_norm), .commit_fast(commit_fast),
    .search_q(search_start_o), .fast_q(fast_start_o), .err_q(err_q));

  clkmul_active #(.W(MULT_W), .RST(MULT_RST)) i_mult_act (
    .clk(clk), .rst_n(rst_n), .load(commit_norm || commit_fast), .d(mult_stg), .q(mult_o));
  clkmul_active #(.W(DIV_W), .RST(DIV_RST)) i_div_act (
    .clk(clk), .rst_n(rst_n), .load(commit_norm || commit_fast), .d(div_stg), .q(div_o));
  clkmul_active #(.W(SEED_W), .RST(SEED_RST)) i_seed_act (
    .clk(clk), .rst_n(rst_n), .load(commit_fast), .d(seed_stg), .q(seed_o));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: begin
        bus_rdata[CB_EN]     = mult_en_i;
        bus_rdata[CB_STABLE] = clk_stable_i;
        bus_rdata[CB_SVALID] = seed_valid_i;
        bus_rdata[CB_ERR]    = err_q;
      end
      REG_MLO: bus_rdata = mult_o[7:0];
      REG_MHI: bus_rdata = 8'(mult_o >> 8);
      REG_DIV: bus_rdata = 8'(div_o);
      REG_SLO: bus_rdata = seed_o[7:0];
      REG_SHI: bus_rdata = 8'(seed_o >> 8);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/clkmul_cfg_checker.sv
module clkmul_cfg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        mult_en_i,
  input logic        clk_stable_i,
  input logic        seed_valid_i,
  input logic [13:0] mult_o,
  input logic [4:0]  div_o,
  input logic [13:0] seed_o,
  input logic        search_start_o,
  input logic        fast_start_o
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && bus_addr == 3'd0;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(search_start_o || fast_start_o) |-> ($stable(mult_o) && $stable(div_o)));
  assert_seed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_start_o |-> $stable(seed_o));
  assert_normal_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[1:0] == 2'b01) |=> (search_start_o && !fast_start_o));
  assert_fast_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[1:0] == 2'b10) |=> (fast_start_o && !search_start_o));
  assert_both_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[1:0] == 2'b11) |=> (!search_start_o && !fast_start_o));
  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(search_start_o && fast_start_o));
  assert_ctrl_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd0) |-> (bus_rdata[1:0] == 2'b00 && bus_rdata[7:6] == 2'b00
      && bus_rdata[2] == mult_en_i && bus_rdata[3] == clk_stable_i && bus_rdata[4] == seed_valid_i));
  assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd3) |-> (bus_rdata[7:5] == 3'b000));
  assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[2:1] == 2'b11) |-> (bus_rdata == 8'h00));
endmodule

bind clkmul_cfg_bank clkmul_cfg_checker i_clkmul_cfg_checker (.*);

// File: tb/test_clkmul_cfg_bank.sv
`timescale 1ns/1ps
module test_clkmul_cfg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        mult_en_i = 1'b1;
  logic        clk_stable_i = 1'b1;
  logic        seed_valid_i = 1'b0;
  logic [13:0] mult_o;
  logic [4:0]  div_o;
  logic [13:0] seed_o;
  logic        search_start_o, fast_start_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkmul_cfg_bank i_clkmul_cfg_bank (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1", "mult", mult_o, 14'h04C5);
    chk("R1", "div", div_o, 5'h0A);
    chk("R1", "seed", seed_o, 0);
    chk("R1", "pulses", {search_start_o, fast_start_o}, 0);
    rd(3'd1, d); chk("R1", "rd mlo", d, 8'hC5);
    rd(3'd2, d); chk("R1", "rd mhi", d, 8'h04);
    rd(3'd3, d); chk("R1", "rd div", d, 8'h0A);
    rd(3'd0, d); chk("R6", "rd ctrl reset", d, 8'h0C);
  endtask

  task automatic t_stage;
    logic [7:0] d;
    wr(3'd1, 8'h12); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd4, 8'h34); wr(3'd5, 8'hC5);
    chk("R2", "mult held", mult_o, 14'h04C5);
    chk("R2", "div held", div_o, 5'h0A);
    chk("R2", "seed held", seed_o, 0);
    rd(3'd1, d); chk("R2", "rd mlo active", d, 8'hC5);
  endtask

  task automatic t_normal;
    logic [7:0] d;
    wr(3'd0, 8'h01);
    chk("R3", "search pulse", search_start_o, 1);
    chk("R3", "no fast", fast_start_o, 0);
    chk("R3", "mult", mult_o, 14'h3F12);
    chk("R3", "div", div_o, 5'h1F);
    chk("R3", "seed kept", seed_o, 0);
    @(negedge clk);
    chk("R3", "pulse width", search_start_o, 0);
    rd(3'd2, d); chk("R7", "rd mhi reserved", d, 8'h3F);
    rd(3'd3, d); chk("R7", "rd div reserved", d, 8'h1F);
  endtask

  task automatic t_fast;
    logic [7:0] d;
    wr(3'd0, 8'h02);
    chk("R4", "fast pulse", fast_start_o, 1);
    chk("R4", "no search", search_start_o, 0);
    chk("R4", "seed", seed_o, 14'h0534);
    chk("R4", "mult", mult_o, 14'h3F12);
    @(negedge clk);
    chk("R4", "pulse width", fast_start_o, 0);
    rd(3'd5, d); chk("R7", "rd shi reserved", d, 8'h05);
    rd(3'd4, d); chk("R4", "rd slo", d, 8'h34);
  endtask

  task automatic t_both;
    logic [7:0] d;
    wr(3'd1, 8'h55);
    wr(3'd0, 8'h03);
    chk("R5", "no pulses", {search_start_o, fast_start_o}, 0);
    chk("R5", "mult unchanged", mult_o, 14'h3F12);
    rd(3'd0, d); chk("R5", "err flag set", d, 8'h2C);
    wr(3'd0, 8'h01);
    chk("R5", "commit after reject", mult_o, 14'h3F55);
    rd(3'd0, d); chk("R5", "err flag cleared", d, 8'h0C);
  endtask

  task automatic t_status;
    logic [7:0] d;
    mult_en_i = 1'b0; clk_stable_i = 1'b0; seed_valid_i = 1'b1;
    rd(3'd0, d); chk("R6", "status mirror", d, 8'h10);
    wr(3'd0, 8'hFC);
    chk("R6", "no pulse on status write", {search_start_o, fast_start_o}, 0);
    rd(3'd0, d); chk("R6", "status write ignored", d, 8'h10);
    mult_en_i = 1'b1; clk_stable_i = 1'b1; seed_valid_i = 1'b0;
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    rd(3'd6, d); chk("R8", "rd addr6", d, 0);
    rd(3'd7, d); chk("R8", "rd addr7", d, 0);
    wr(3'd6, 8'hAA); wr(3'd7, 8'hFF);
    wr(3'd0, 8'h02);
    chk("R8", "mult after unmapped", mult_o, 14'h3F55);
    chk("R9", "div recommitted", div_o, 5'h1F);
    chk("R9", "seed recommitted", seed_o, 14'h0534);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage();
    t_normal();
    t_fast();
    t_both();
    t_status();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule